// File: doc/BRIEF.md
# I2C Master Start Reservation Controller

This block works beside an I2C byte engine and decides when the local master may put a START condition on the bus. It follows the synchronised SCL and SDA lines, marks the bus busy from a START until the next STOP, and reacts to a software start request. If the bus is free when the request rises, it drives a START at once. If the bus is busy and reservation is allowed, it keeps the request pending and fires the START by itself when it sees the next STOP.

After the START it pulls SCL low and holds the bus in a wait state until a first address byte is present. It then hands that byte to the byte engine with a one-cycle valid pulse and releases both lines. Address writes made while the block is not yet master, including any made while a reservation is pending, are discarded. A STOP can raise an interrupt pulse. Arbitration loss and a software release both end master status.

Top module: `i2c_start_rsv`

## Requirements
- R1: A rising edge on `start_req_i` while the bus is free pulses `start_o` and sets `mst_o` on the next clock edge, whatever `rsv_block_i` is.
- R2: The bus is busy from a START (SDA falling while SCL is high on two consecutive samples) until a STOP (SDA rising while SCL is high on two consecutive samples). A request rising while the bus is busy with `rsv_block_i` = 0 becomes pending: no START and `mst_o` stays 0 until the next STOP, after which `start_o` pulses and `mst_o` rises.
- R3: With `rsv_block_i` = 1, a request rising while the bus is busy is dropped, and no START follows the next STOP.
- R4: A pending reservation is cancelled when `start_req_i` falls or `release_i` is pulsed before the STOP. No START follows that STOP.
- R5: The START waveform pulls SDA low (`sda_oe_o` = 1, `scl_oe_o` = 0) for `thigh_i` cycles, then also pulls SCL low for `tlow_i` cycles before the wait state. A count of zero acts as one.
- R6: After the START waveform, `wait_o` is 1 and both lines stay pulled low until an address byte is held. The block then pulses `addr_vld_o` for one cycle with the byte on `addr_o`, drops `wait_o` and releases both lines.
- R7: An `addr_wr_i` pulse is accepted only while the block is master and before handoff. Writes made while idle or while a reservation is pending have no effect. The byte handed off is the last one accepted.
- R8: With `stop_ie_i` = 1, each detected STOP gives a one-cycle `stop_irq_o` pulse. With `stop_ie_i` = 0, no pulse is given.
- R9: A pulse on `arb_lost_i` or `release_i` clears `mst_o` and releases both lines on the next clock edge. A request rising in the same cycle is ignored.
- R10: `mst_o` shows the outcome of a request (1 for an immediate START, 0 for a reservation) no later than `tlow_i` + `thigh_i` + 4 cycles after the request rises.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| start_req_i | input | 1 | Start request level; its rising edge asks for a START, and a low level cancels a pending one |
| rsv_block_i | input | 1 | 1 = do not hold requests made while the bus is busy |
| release_i | input | 1 | Pulse: leave master state and cancel any reservation |
| arb_lost_i | input | 1 | Pulse: arbitration lost |
| stop_ie_i | input | 1 | Enables the STOP interrupt |
| addr_wr_i | input | 1 | Address write strobe |
| addr_i | input | AW | Address byte to write |
| thigh_i | input | CW | START hold count (SCL high, SDA low) |
| tlow_i | input | CW | SCL low count after the START |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| start_o | output | 1 | One-cycle pulse when a START begins |
| mst_o | output | 1 | Master status |
| wait_o | output | 1 | Waiting for the address byte after a START |
| stop_irq_o | output | 1 | One-cycle STOP interrupt |
| addr_vld_o | output | 1 | One-cycle handoff pulse for `addr_o` |
| addr_o | output | AW | Address byte handed to the byte engine |

## Verification
The bench covers the four outcomes of a request: free bus, busy bus with reservation, busy bus with reservation blocked, and a reservation cancelled either by dropping the request or by a release pulse. A design that mixes these up either drives a START onto a busy bus or fires a START that software has already withdrawn. It also writes an address while a reservation is pending and checks that the block still waits after the START. A design that kept the stale byte would hand it off with no new write. The bench counts the cycles of each START phase, including a zero count, and checks the STOP interrupt with the enable both on and off. Abort pulses are checked to release the lines on the next cycle, so a design that left SDA pulled low would hang the bus.

// File: rtl/i2c_rsv_pkg.sv
`timescale 1ns/1ps
package i2c_rsv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PEND   = 3'd1,
        ST_GEN_H  = 3'd2,
        ST_GEN_L  = 3'd3,
        ST_WAIT   = 3'd4,
        ST_ACTIVE = 3'd5
    } rsv_state_e;

    typedef struct packed {
        logic scl_p;
        logic sda_p;
        logic busy;
    } det_regs_t;

endpackage

// File: rtl/i2c_rsv_sync.sv
`timescale 1ns/1ps
module i2c_rsv_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    logic [STAGES-1:0][LINES-1:0] pipe_d, pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb pipe_d[s] = din;
            end else begin : g_next
                always_comb pipe_d[s] = pipe_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_rsv_cond_det.sv
`timescale 1ns/1ps
module i2c_rsv_cond_det
    import i2c_rsv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic bus_busy
);
    det_regs_t d, q;

    always_comb begin
        start_det = q.scl_p & scl_s & q.sda_p & ~sda_s;
        stop_det  = q.scl_p & scl_s & ~q.sda_p & sda_s;
        d         = q;
        d.scl_p   = scl_s;
        d.sda_p   = sda_s;
        if (stop_det)       d.busy = 1'b0;
        else if (start_det) d.busy = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0};
        else        q <= d;
    end

    assign bus_busy = q.busy;
endmodule

// File: rtl/i2c_rsv_phase_timer.sv
`timescale 1ns/1ps
module i2c_rsv_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          done_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
        done_o  = cnt_inc >= {1'b0, limit_i};
        cnt_d   = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (run_i) cnt_d = cnt_inc[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_rsv_fsm.sv
`timescale 1ns/1ps
module i2c_rsv_fsm
    import i2c_rsv_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_busy_i,
    input  logic          stop_det_i,
    input  logic          start_req_i,
    input  logic          rsv_block_i,
    input  logic          release_i,
    input  logic          arb_lost_i,
    input  logic          stop_ie_i,
    input  logic          addr_wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] thigh_i,
    input  logic [CW-1:0] tlow_i,
    input  logic          tmr_done_i,
    output logic          tmr_clr_o,
    output logic          tmr_run_o,
    output logic [CW-1:0] tmr_limit_o,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    output logic          start_o,
    output logic          mst_o,
    output logic          wait_o,
    output logic          stop_irq_o,
    output logic          addr_vld_o,
    output logic [AW-1:0] addr_o
);
    typedef struct packed {
        rsv_state_e    st;
        logic          req_p;
        logic          mst;
        logic          start;
        logic          irq;
        logic          vld;
        logic          have;
        logic [AW-1:0] addr;
    } fsm_regs_t;

    fsm_regs_t d, q;
    logic req_rise, abort, in_master;

    always_comb begin
        req_rise  = start_req_i & ~q.req_p;
        abort     = release_i | arb_lost_i;
        in_master = (q.st == ST_GEN_H) || (q.st == ST_GEN_L) || (q.st == ST_WAIT);

        d         = q;
        d.req_p   = start_req_i;
        d.start   = 1'b0;
        d.vld     = 1'b0;
        d.irq     = stop_det_i & stop_ie_i;
        tmr_clr_o = 1'b0;
        tmr_run_o = 1'b0;

        if (addr_wr_i && in_master) begin
            d.addr = addr_i;
            d.have = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (!abort && req_rise) begin
                    if (!bus_busy_i) begin
                        d.st      = ST_GEN_H;
                        d.start   = 1'b1;
                        d.mst     = 1'b1;
                        d.have    = 1'b0;
                        tmr_clr_o = 1'b1;
                    end else if (!rsv_block_i) begin
                        d.st = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (abort || !start_req_i) begin
                    d.st = ST_IDLE;
                end else if (stop_det_i) begin
                    d.st      = ST_GEN_H;
                    d.start   = 1'b1;
                    d.mst     = 1'b1;
                    d.have    = 1'b0;
                    tmr_clr_o = 1'b1;
                end
            end
            ST_GEN_H: begin
                tmr_run_o = 1'b1;
                if (tmr_done_i) begin
                    d.st      = ST_GEN_L;
                    tmr_clr_o = 1'b1;
                end
            end
            ST_GEN_L: begin
                tmr_run_o = 1'b1;
                if (tmr_done_i) begin
                    d.st      = ST_WAIT;
                    tmr_clr_o = 1'b1;
                end
            end
            ST_WAIT: begin
                if (q.have) begin
                    d.st   = ST_ACTIVE;
                    d.vld  = 1'b1;
                    d.have = 1'b0;
                end
            end
            ST_ACTIVE: begin
                if (stop_det_i) begin
                    d.st  = ST_IDLE;
                    d.mst = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (q.st == ST_WAIT && stop_det_i) begin
            d.st  = ST_IDLE;
            d.mst = 1'b0;
            d.vld = 1'b0;
        end

        if (abort && q.st != ST_IDLE) begin
            d.st   = ST_IDLE;
            d.mst  = 1'b0;
            d.vld  = 1'b0;
            d.have = 1'b0;
        end
        if (abort) d.start = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign tmr_limit_o = (q.st == ST_GEN_H) ? thigh_i : tlow_i;
    assign sda_oe_o    = in_master;
    assign scl_oe_o    = (q.st == ST_GEN_L) || (q.st == ST_WAIT);
    assign wait_o      = (q.st == ST_WAIT);
    assign start_o     = q.start;
    assign mst_o       = q.mst;
    assign stop_irq_o  = q.irq;
    assign addr_vld_o  = q.vld;
    assign addr_o      = q.addr;
endmodule

// File: rtl/i2c_start_rsv.sv
`timescale 1ns/1ps
module i2c_start_rsv #(
    parameter int AW          = 8,
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          start_req_i,
    input  logic          rsv_block_i,
    input  logic          release_i,
    input  logic          arb_lost_i,
    input  logic          stop_ie_i,
    input  logic          addr_wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] thigh_i,
    input  logic [CW-1:0] tlow_i,
    output logic          scl_oe_o,
    output logic          sda_oe_o,
    output logic          start_o,
    output logic          mst_o,
    output logic          wait_o,
    output logic          stop_irq_o,
    output logic          addr_vld_o,
    output logic [AW-1:0] addr_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    logic             start_det, stop_det, bus_busy;
    logic             tmr_clr, tmr_run, tmr_done;
    logic [CW-1:0]    tmr_limit;

    i2c_rsv_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (lines_s)
    );

    i2c_rsv_cond_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .start_det(start_det),
        .stop_det (stop_det),
        .bus_busy (bus_busy)
    );

    i2c_rsv_phase_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .run_i  (tmr_run),
        .limit_i(tmr_limit),
        .done_o (tmr_done)
    );

    i2c_rsv_fsm #(.AW(AW), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_busy_i (bus_busy),
        .stop_det_i (stop_det),
        .start_req_i(start_req_i),
        .rsv_block_i(rsv_block_i),
        .release_i  (release_i),
        .arb_lost_i (arb_lost_i),
        .stop_ie_i  (stop_ie_i),
        .addr_wr_i  (addr_wr_i),
        .addr_i     (addr_i),
        .thigh_i    (thigh_i),
        .tlow_i     (tlow_i),
        .tmr_done_i (tmr_done),
        .tmr_clr_o  (tmr_clr),
        .tmr_run_o  (tmr_run),
        .tmr_limit_o(tmr_limit),
        .scl_oe_o   (scl_oe_o),
        .sda_oe_o   (sda_oe_o),
        .start_o    (start_o),
        .mst_o      (mst_o),
        .wait_o     (wait_o),
        .stop_irq_o (stop_irq_o),
        .addr_vld_o (addr_vld_o),
        .addr_o     (addr_o)
    );

    logic unused_start_det;
    assign unused_start_det = start_det;
endmodule

// File: rtl/i2c_start_rsv_chk.sv
`timescale 1ns/1ps
module i2c_start_rsv_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_det,
    input logic stop_ie_i,
    input logic arb_lost_i,
    input logic release_i,
    input logic start_o,
    input logic mst_o,
    input logic sda_oe_o,
    input logic scl_oe_o,
    input logic wait_o,
    input logic stop_irq_o,
    input logic addr_vld_o
);
    a_r1_start_sets_mst: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (mst_o && sda_oe_o && !scl_oe_o));

    a_r5_scl_needs_sda: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> sda_oe_o);

    a_r6_wait_holds_lines: assert property (@(posedge clk) disable iff (!rst_n)
        wait_o |-> (scl_oe_o && mst_o));

    a_r6_handoff_releases: assert property (@(posedge clk) disable iff (!rst_n)
        addr_vld_o |-> (mst_o && !wait_o && !sda_oe_o));

    a_r8_irq_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && stop_ie_i) |=> stop_irq_o);

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_ie_i |=> !stop_irq_o);

    a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i || release_i) |=> (!mst_o && !sda_oe_o && !scl_oe_o && !start_o));
endmodule

bind i2c_start_rsv i2c_start_rsv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_det  (stop_det),
    .stop_ie_i (stop_ie_i),
    .arb_lost_i(arb_lost_i),
    .release_i (release_i),
    .start_o   (start_o),
    .mst_o     (mst_o),
    .sda_oe_o  (sda_oe_o),
    .scl_oe_o  (scl_oe_o),
    .wait_o    (wait_o),
    .stop_irq_o(stop_irq_o),
    .addr_vld_o(addr_vld_o)
);

// File: tb/i2c_start_rsv_tb.sv
`timescale 1ns/1ps
module i2c_start_rsv_tb;
    localparam int AW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_d = 1'b1, sda_d = 1'b1;
    logic start_req = 1'b0, rsv_block = 1'b0, rel = 1'b0, arb = 1'b0, stop_ie = 1'b0;
    logic addr_wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] thigh = 8'd3, tlow = 8'd5;
    logic scl_oe, sda_oe, start_p, mst, wt, irq, vld;
    logic [AW-1:0] addr_out;
    logic scl_line, sda_line;

    int checks = 0, errors = 0;
    int n_start = 0, n_gh = 0, n_gl = 0, n_irq = 0, n_vld = 0;
    logic [AW-1:0] last_addr = '0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign scl_line = scl_d & ~scl_oe;
    assign sda_line = sda_d & ~sda_oe;

    i2c_start_rsv #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .start_req_i(start_req), .rsv_block_i(rsv_block), .release_i(rel),
        .arb_lost_i(arb), .stop_ie_i(stop_ie), .addr_wr_i(addr_wr), .addr_i(addr),
        .thigh_i(thigh), .tlow_i(tlow), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .start_o(start_p), .mst_o(mst), .wait_o(wt), .stop_irq_o(irq),
        .addr_vld_o(vld), .addr_o(addr_out)
    );

    always @(posedge clk) begin
        #1;
        n_start += int'(start_p);
        n_gh    += int'(sda_oe & ~scl_oe);
        n_gl    += int'(scl_oe & ~wt);
        n_irq   += int'(irq);
        if (vld) begin
            n_vld++;
            last_addr = addr_out;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_d = 1'b0; tick(4);
        scl_d = 1'b0; tick(3);
    endtask

    task automatic bus_stop();
        scl_d = 1'b0; tick(3);
        sda_d = 1'b0; tick(3);
        scl_d = 1'b1; tick(3);
        sda_d = 1'b1; tick(8);
    endtask

    task automatic pulse_rel();
        rel = 1'b1; tick(1); rel = 1'b0;
    endtask

    task automatic write_addr(input logic [AW-1:0] v);
        addr = v; addr_wr = 1'b1; tick(1); addr_wr = 1'b0;
    endtask

    task automatic cleanup();
        start_req = 1'b0;
        pulse_rel();
        tick(2);
        bus_stop();
    endtask

    // [6] bus busy, [5] reservation blocked, [4:3] cancel (0 none, 1 drop request, 2 release),
    // [2] expected master right after the request, [1:0] expected STARTs after the STOP
    localparam logic [6:0] VEC [0:5] = '{
        7'b0_0_00_1_01,
        7'b0_1_00_1_01,
        7'b1_0_00_0_01,
        7'b1_1_00_0_00,
        7'b1_0_01_0_00,
        7'b1_0_10_0_00
    };

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0, v0, i0, gh0, gl0;
        tick(3);
        // R11: reset state
        chk("R11 outputs in reset", int'({scl_oe, sda_oe, start_p, mst, wt, irq, vld}), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R11 outputs after reset", int'({scl_oe, sda_oe, start_p, mst, wt, irq, vld}), 0);

        // Vector loop: R1, R2, R3, R4, R10
        for (int k = 0; k < 6; k++) begin
            logic [6:0] v;
            v = VEC[k];
            rsv_block = v[5];
            if (v[6]) bus_start();
            s0 = n_start;
            start_req = 1'b1;
            tick(3);
            chk($sformatf("R10 vec%0d master flag", k), int'(mst), int'(v[2]));
            chk($sformatf("R1 vec%0d immediate START", k), n_start - s0, int'(v[2]));
            if (v[6]) begin
                if (v[4:3] == 2'd1) begin start_req = 1'b0; tick(2); end
                if (v[4:3] == 2'd2) begin pulse_rel(); tick(2); end
                bus_stop();
                chk($sformatf("R2 R3 R4 vec%0d STARTs after STOP", k), n_start - s0, int'(v[1:0]));
                chk($sformatf("R2 vec%0d master after STOP", k), int'(mst), int'(v[1:0] != 0));
            end
            cleanup();
        end
        rsv_block = 1'b0;

        // R5 R6 R7: waveform, wait and handoff from a free bus
        write_addr(8'h11);
        gh0 = n_gh; gl0 = n_gl; v0 = n_vld;
        start_req = 1'b1;
        tick(14);
        chk("R5 SDA-only phase cycles", n_gh - gh0, 3);
        chk("R5 SCL low phase cycles", n_gl - gl0, 5);
        chk("R6 wait after START", int'(wt), 1);
        chk("R7 idle write ignored", n_vld - v0, 0);
        write_addr(8'hA5);
        tick(3);
        chk("R6 handoff pulse", n_vld - v0, 1);
        chk("R7 handed address", int'(last_addr), 8'hA5);
        chk("R6 lines released", int'({wt, scl_oe, sda_oe}), 0);
        cleanup();

        // R5: zero counts act as one
        thigh = 8'd0; tlow = 8'd0;
        gh0 = n_gh; gl0 = n_gl;
        start_req = 1'b1;
        tick(6);
        chk("R5 zero high count", n_gh - gh0, 1);
        chk("R5 zero low count", n_gl - gl0, 1);
        cleanup();
        thigh = 8'd3; tlow = 8'd5;

        // R7: address written during a pending reservation is dropped
        bus_start();
        v0 = n_vld;
        start_req = 1'b1;
        tick(2);
        write_addr(8'h3C);
        tick(2);
        bus_stop();
        tick(8);
        chk("R7 master after reserved START", int'(mst), 1);
        chk("R7 pending write dropped: still waiting", int'(wt), 1);
        chk("R7 no handoff from pending write", n_vld - v0, 0);
        write_addr(8'h96);
        tick(3);
        chk("R7 handoff after new write", n_vld - v0, 1);
        chk("R7 handed address after reservation", int'(last_addr), 8'h96);
        cleanup();

        // R8: STOP interrupt enable
        stop_ie = 1'b1;
        i0 = n_irq;
        bus_stop();
        chk("R8 irq on STOP", n_irq - i0, 1);
        stop_ie = 1'b0;
        i0 = n_irq;
        bus_stop();
        chk("R8 no irq when disabled", n_irq - i0, 0);

        // R9: arbitration loss
        start_req = 1'b1;
        tick(2);
        arb = 1'b1; tick(1); arb = 1'b0;
        chk("R9 master cleared", int'(mst), 0);
        chk("R9 lines released", int'({scl_oe, sda_oe}), 0);
        cleanup();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule